// File: doc/BRIEF.md
# Clock Frequency Source Selector

This block chooses the frequency setting that a clock synthesizer runs at, and it marks each change of that setting with a load pulse. When power-good first goes low after reset, the block captures five frequency-select straps and holds them. From then on the block picks the active setting from one of three sources, highest priority first: a recovery setting while the watchdog holds the part in recovery, a programmed N/M divider pair, or a 5-bit ratio select. The ratio select comes either from the held straps or from select bits in a control byte.

The register file gives the block the control byte, the programmed and recovery divider values, and one write strobe per divider byte. It also gives an end-of-transaction marker for each bus transaction. A divider write takes effect only when the transaction closes. Only then does the block check the ratio, commit the pair and raise one change pulse, however many divider bytes the transaction wrote. A pair whose (N+3) is not greater than (M+3) is rejected and the previous pair is kept. Every output comes from a register and follows its inputs with one cycle of latency.

Top module: `freq_src_sel`

## Requirements
- R1: The straps are captured on the first clock edge after reset at which `pwrGoodN` is low, and `outEn` goes high on that edge. Later changes on the straps or on `pwrGoodN` do not alter the captured value until the next reset.
- R2: `strapRd` carries the captured straps in bits 7:3, with FS4 in bit 7 down to FS0 in bit 3. Bits 2:0 are zero. The whole byte reads zero before capture.
- R3: When control bit 3 (override) is 0, `effSel` equals the captured straps. When it is 1, `effSel` = {ctrl[2], ctrl[1], ctrl[6], ctrl[5], ctrl[4]}, which is SEL4 down to SEL0.
- R4: `spreadCode` equals {ctrl[7], ctrl[0]}.
- R5: When recovery is off and `progEn` is 1, `useNM` is 1 and `effN`/`effM` show the committed programmed pair. `effSel` still follows R3.
- R6: Whenever `useNM` is 0, `effN` and `effM` read zero. With recovery off and `progEn` 0, `useNM` is 0.
- R7: A transaction with one or more N/M write strobes ends with `txnEnd`. A strobe in the `txnEnd` cycle itself also counts. If progN > progM, the pair is committed and `freqChg` is high for exactly one cycle, one cycle after `txnEnd`. This holds whether or not `progEn` is set.
- R8: While `recovMode` is 1, write strobes and `txnEnd` are ignored and any pending write is dropped. No commit, no `freqChg` from writes and no `cfgReject` result.
- R9: In recovery with `recovSel` 0, `useNM` is 0 and `effSel` equals the captured straps, whatever the override bit says. With `recovSel` 1, `useNM` is 1, `effN`/`effM` equal `recovN`/`recovM`, and `effSel` follows R3.
- R10: If the pair at transaction end has progN <= progM, `cfgReject` pulses for one cycle, the committed pair does not change and `freqChg` stays low.
- R11: Entering or leaving recovery raises `freqChg` for one cycle, one cycle after `recovMode` changes.
- R12: All outputs are zero in reset. All outputs reflect the inputs of the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrGoodN | input | 1 | Active-low power-good; first low level captures the straps |
| strapIn | input | 5 | Frequency-select straps, FS4 in bit 4 |
| ctrlByte | input | 8 | Control byte: select bits, override (bit 3), spread code bits |
| progEn | input | 1 | Programmable N/M frequency enable |
| progN | input | NBITS | Programmed N register value |
| progM | input | MBITS | Programmed M register value |
| nWrStb | input | 1 | One-cycle strobe: N register written |
| mWrStb | input | 1 | One-cycle strobe: M register written |
| txnEnd | input | 1 | One-cycle marker: bus transaction finished |
| recovMode | input | 1 | Watchdog recovery mode is active |
| recovSel | input | 1 | Recovery source: 0 straps, 1 recovery N/M pair |
| recovN | input | NBITS | Recovery N value |
| recovM | input | MBITS | Recovery M value |
| outEn | output | 1 | Straps captured, clock outputs enabled |
| strapRd | output | 8 | Read-only strap byte |
| effSel | output | 5 | Effective ratio/gear select |
| effN | output | NBITS | Effective N value |
| effM | output | MBITS | Effective M value |
| useNM | output | 1 | Synthesizer uses the N/M pair |
| spreadCode | output | 2 | Spread mode code |
| freqChg | output | 1 | One-cycle frequency load pulse |
| cfgReject | output | 1 | One-cycle pulse: programmed ratio rejected |

## Verification
All 32 strap values are captured after separate resets. Each capture is followed by a strap change, which shows whether the capture is truly held. All 256 control bytes are applied with override set and clear, which tells the strap path from the register path and exposes any misplaced select bit or spread bit. A 16-by-16 sweep of N/M pairs crosses the N>M boundary in both directions, including N equal to M, and confirms a single pulse for two-strobe transactions. Recovery tests separate the two recovery sources, writes made inside recovery, and a pending write that spans a recovery episode.

// File: rtl/freq_sel_pkg.sv
package freq_sel_pkg;
  localparam int SEL_W = 5;

  typedef struct packed {
    logic capStrap;   // take strap snapshot this cycle
    logic commit;     // load programmed N/M pair
    logic reject;     // programmed pair failed ratio check
    logic recovEdge;  // recovery mode toggled
  } sel_strobe_t;
endpackage

// File: rtl/freq_sel_ctrl.sv
module freq_sel_ctrl
  import freq_sel_pkg::*;
#(
  parameter int NBITS = 8,
  parameter int MBITS = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwrGoodN,
  input  logic             nWrStb,
  input  logic             mWrStb,
  input  logic             txnEnd,
  input  logic             recovMode,
  input  logic [NBITS-1:0] progN,
  input  logic [MBITS-1:0] progM,
  output sel_strobe_t      stb,
  output logic             outEn
);
  localparam int CMP_W = ((NBITS > MBITS) ? NBITS : MBITS) + 1;

  logic latchedQ;
  logic pendQ;
  logic recovPrevQ;
  logic wrAny;
  logic pendNow;
  logic atEnd;
  logic ratioOk;

  // (N+3) > (M+3) reduces to N > M
  assign ratioOk = CMP_W'(progN) > CMP_W'(progM);
  assign wrAny   = nWrStb | mWrStb;
  assign pendNow = !recovMode && (pendQ || wrAny);
  assign atEnd   = txnEnd && pendNow;

  always_comb begin
    stb           = '0;
    stb.capStrap  = !pwrGoodN && !latchedQ;
    stb.commit    = atEnd && ratioOk;
    stb.reject    = atEnd && !ratioOk;
    stb.recovEdge = recovMode != recovPrevQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchedQ   <= 1'b0;
      pendQ      <= 1'b0;
      recovPrevQ <= 1'b0;
    end else begin
      recovPrevQ <= recovMode;
      if (stb.capStrap) latchedQ <= 1'b1;
      if (recovMode || txnEnd) pendQ <= 1'b0;
      else if (wrAny)          pendQ <= 1'b1;
    end
  end

  assign outEn = latchedQ;
endmodule

// File: rtl/freq_sel_dp.sv
module freq_sel_dp
  import freq_sel_pkg::*;
#(
  parameter int NBITS = 8,
  parameter int MBITS = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  sel_strobe_t      stb,
  input  logic [SEL_W-1:0] strapIn,
  input  logic [7:0]       ctrlByte,
  input  logic             progEn,
  input  logic [NBITS-1:0] progN,
  input  logic [MBITS-1:0] progM,
  input  logic             recovMode,
  input  logic             recovSel,
  input  logic [NBITS-1:0] recovN,
  input  logic [MBITS-1:0] recovM,
  output logic [7:0]       strapRd,
  output logic [SEL_W-1:0] effSel,
  output logic [NBITS-1:0] effN,
  output logic [MBITS-1:0] effM,
  output logic             useNM,
  output logic [1:0]       spreadCode,
  output logic             freqChg,
  output logic             cfgReject
);
  localparam int RD_LSB = 8 - SEL_W;

  logic [SEL_W-1:0] strapQ, strapNext, regSel, ratioSel, selNext;
  logic [NBITS-1:0] activeN, actNNext, nNext;
  logic [MBITS-1:0] activeM, actMNext, mNext;
  logic             nmNext;

  assign strapNext = stb.capStrap ? strapIn : strapQ;
  // select bits are scattered over the control byte: SEL4..SEL0
  assign regSel    = {ctrlByte[2], ctrlByte[1], ctrlByte[6], ctrlByte[5], ctrlByte[4]};
  assign ratioSel  = ctrlByte[3] ? regSel : strapNext;
  assign actNNext  = stb.commit ? progN : activeN;
  assign actMNext  = stb.commit ? progM : activeM;

  always_comb begin
    selNext = ratioSel;
    nmNext  = 1'b0;
    nNext   = '0;
    mNext   = '0;
    if (recovMode) begin
      if (recovSel) begin
        nmNext = 1'b1;
        nNext  = recovN;
        mNext  = recovM;
      end else begin
        selNext = strapNext;
      end
    end else if (progEn) begin
      nmNext = 1'b1;
      nNext  = actNNext;
      mNext  = actMNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapQ     <= '0;
      activeN    <= '0;
      activeM    <= '0;
      effSel     <= '0;
      effN       <= '0;
      effM       <= '0;
      useNM      <= 1'b0;
      spreadCode <= 2'b00;
      freqChg    <= 1'b0;
      cfgReject  <= 1'b0;
    end else begin
      strapQ     <= strapNext;
      activeN    <= actNNext;
      activeM    <= actMNext;
      effSel     <= selNext;
      effN       <= nNext;
      effM       <= mNext;
      useNM      <= nmNext;
      spreadCode <= {ctrlByte[7], ctrlByte[0]};
      freqChg    <= stb.commit | stb.recovEdge;
      cfgReject  <= stb.reject;
    end
  end

  // readback byte: strap k sits at bit RD_LSB+k
  for (genvar k = 0; k < SEL_W; k++) begin : g_rd
    assign strapRd[RD_LSB+k] = strapQ[k];
  end
  assign strapRd[RD_LSB-1:0] = '0;
endmodule

// File: rtl/freq_src_sel.sv
module freq_src_sel
  import freq_sel_pkg::*;
#(
  parameter int NBITS = 8,
  parameter int MBITS = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwrGoodN,
  input  logic [4:0]       strapIn,
  input  logic [7:0]       ctrlByte,
  input  logic             progEn,
  input  logic [NBITS-1:0] progN,
  input  logic [MBITS-1:0] progM,
  input  logic             nWrStb,
  input  logic             mWrStb,
  input  logic             txnEnd,
  input  logic             recovMode,
  input  logic             recovSel,
  input  logic [NBITS-1:0] recovN,
  input  logic [MBITS-1:0] recovM,
  output logic             outEn,
  output logic [7:0]       strapRd,
  output logic [4:0]       effSel,
  output logic [NBITS-1:0] effN,
  output logic [MBITS-1:0] effM,
  output logic             useNM,
  output logic [1:0]       spreadCode,
  output logic             freqChg,
  output logic             cfgReject
);
  sel_strobe_t stb;

  freq_sel_ctrl #(.NBITS(NBITS), .MBITS(MBITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .pwrGoodN(pwrGoodN),
    .nWrStb(nWrStb), .mWrStb(mWrStb), .txnEnd(txnEnd),
    .recovMode(recovMode), .progN(progN), .progM(progM),
    .stb(stb), .outEn(outEn)
  );

  freq_sel_dp #(.NBITS(NBITS), .MBITS(MBITS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .strapIn(strapIn),
    .ctrlByte(ctrlByte), .progEn(progEn), .progN(progN), .progM(progM),
    .recovMode(recovMode), .recovSel(recovSel), .recovN(recovN), .recovM(recovM),
    .strapRd(strapRd), .effSel(effSel), .effN(effN), .effM(effM),
    .useNM(useNM), .spreadCode(spreadCode), .freqChg(freqChg), .cfgReject(cfgReject)
  );
endmodule

// File: rtl/freq_src_sel_chk.sv
module freq_src_sel_chk #(
  parameter int NBITS = 8,
  parameter int MBITS = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic [7:0]       ctrlByte,
  input logic             recovMode,
  input logic             outEn,
  input logic [7:0]       strapRd,
  input logic [4:0]       effSel,
  input logic [NBITS-1:0] effN,
  input logic [MBITS-1:0] effM,
  input logic             useNM,
  input logic [1:0]       spreadCode,
  input logic             freqChg,
  input logic             cfgReject
);
  p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    outEn |=> (outEn && $stable(strapRd)));

  p_override_sel_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!recovMode && ctrlByte[3])) |->
      (effSel == {$past(ctrlByte[2]), $past(ctrlByte[1]), $past(ctrlByte[6:4])}));

  p_spread_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (spreadCode == {$past(ctrlByte[7]), $past(ctrlByte[0])}));

  p_nm_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    !useNM |-> (effN == '0 && effM == '0));

  p_recov_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2) && $past(recovMode) && $past(recovMode, 2)) |->
      (!freqChg && !cfgReject));

  p_reject_nochg_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReject && $past(rstN, 2) && ($past(recovMode) == $past(recovMode, 2))) |-> !freqChg);
endmodule

bind freq_src_sel freq_src_sel_chk #(.NBITS(NBITS), .MBITS(MBITS)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlByte(ctrlByte), .recovMode(recovMode),
  .outEn(outEn), .strapRd(strapRd), .effSel(effSel), .effN(effN), .effM(effM),
  .useNM(useNM), .spreadCode(spreadCode), .freqChg(freqChg), .cfgReject(cfgReject)
);

// File: tb/freq_src_sel_bench.sv
module freq_src_sel_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrGoodN = 1'b1;
  logic [4:0] strapIn = '0;
  logic [7:0] ctrlByte = '0;
  logic       progEn = 1'b0;
  logic [7:0] progN = '0;
  logic [6:0] progM = '0;
  logic       nWrStb = 1'b0, mWrStb = 1'b0, txnEnd = 1'b0;
  logic       recovMode = 1'b0, recovSel = 1'b0;
  logic [7:0] recovN = '0;
  logic [6:0] recovM = '0;
  logic       outEn;
  logic [7:0] strapRd;
  logic [4:0] effSel;
  logic [7:0] effN;
  logic [6:0] effM;
  logic       useNM;
  logic [1:0] spreadCode;
  logic       freqChg, cfgReject;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] expN = '0;
  logic [6:0] expM = '0;
  logic [4:0] held = '0;

  always #5 clk = ~clk;

  freq_src_sel u_freq_src_sel (
    .clk(clk), .rstN(rstN), .pwrGoodN(pwrGoodN), .strapIn(strapIn),
    .ctrlByte(ctrlByte), .progEn(progEn), .progN(progN), .progM(progM),
    .nWrStb(nWrStb), .mWrStb(mWrStb), .txnEnd(txnEnd),
    .recovMode(recovMode), .recovSel(recovSel), .recovN(recovN), .recovM(recovM),
    .outEn(outEn), .strapRd(strapRd), .effSel(effSel), .effN(effN), .effM(effM),
    .useNM(useNM), .spreadCode(spreadCode), .freqChg(freqChg), .cfgReject(cfgReject)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [4:0] regSelOf(input logic [7:0] c);
    return {c[2], c[1], c[6], c[5], c[4]};
  endfunction

  task automatic doReset(input logic [4:0] s);
    rstN = 1'b0; pwrGoodN = 1'b1; strapIn = s; ctrlByte = '0; progEn = 1'b0;
    recovMode = 1'b0; recovSel = 1'b0;
    step(); step();
    rstN = 1'b1;
    step();
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    @(negedge clk);
    // R12 reset state
    step();
    chk("R12 reset outEn", outEn, 0);
    chk("R12 reset effSel", effSel, 0);
    chk("R12 reset freqChg", freqChg, 0);

    // R1 R2 R3: every strap value, each after its own reset
    for (int s = 0; s < 32; s++) begin
      doReset(5'(s));
      chk("R2 before capture", strapRd, 0);
      chk("R1 outEn before capture", outEn, 0);
      pwrGoodN = 1'b0;
      step();
      chk("R1 outEn after capture", outEn, 1);
      chk("R2 strap byte", strapRd, {s[4:0], 3'b000});
      chk("R3 straps drive select", effSel, s[4:0]);
      strapIn = ~5'(s); pwrGoodN = 1'b1;
      step();
      pwrGoodN = 1'b0;
      step();
      chk("R1 capture held", strapRd, {s[4:0], 3'b000});
      chk("R1 select held", effSel, s[4:0]);
    end

    held = 5'b10110;
    doReset(held);
    pwrGoodN = 1'b0;
    step();

    // R3 R4 R6: all control bytes
    for (int c = 0; c < 256; c++) begin
      ctrlByte = 8'(c);
      step();
      chk("R3 effective select", effSel, c[3] ? regSelOf(8'(c)) : held);
      chk("R4 spread code", spreadCode, {c[7], c[0]});
      chk("R6 no N/M", {useNM, effN, effM}, 0);
    end

    // R5 R7 R10: ratio sweep, two-strobe transactions
    ctrlByte = 8'h00; progEn = 1'b1;
    for (int n = 0; n < 16; n++) begin
      for (int m = 0; m < 16; m++) begin
        progN = 8'(n); progM = 7'(m); nWrStb = 1'b1;
        step();
        chk("R7 no load mid transaction", freqChg, 0);
        chk("R5 committed N shown", effN, expN);
        nWrStb = 1'b0; mWrStb = 1'b1; txnEnd = 1'b1;
        step();
        if (n > m) begin expN = 8'(n); expM = 7'(m); end
        chk("R7 load pulse", freqChg, n > m);
        chk("R10 reject pulse", cfgReject, n <= m);
        chk("R5 useNM", useNM, 1);
        chk("R5 N after end", effN, expN);
        chk("R10 M kept or loaded", effM, expM);
        chk("R5 select from straps", effSel, held);
        mWrStb = 1'b0; txnEnd = 1'b0;
        step();
        chk("R7 single pulse", freqChg, 0);
        chk("R10 single reject", cfgReject, 0);
      end
    end

    // R7: strobes and end in one cycle, progEn off
    progEn = 1'b0; progN = 8'd120; progM = 7'd45;
    nWrStb = 1'b1; mWrStb = 1'b1; txnEnd = 1'b1;
    step();
    nWrStb = 1'b0; mWrStb = 1'b0; txnEnd = 1'b0;
    expN = 8'd120; expM = 7'd45;
    chk("R7 one-cycle transaction pulse", freqChg, 1);
    chk("R6 progEn off", {useNM, effN, effM}, 0);
    step();
    chk("R7 pulse ends", freqChg, 0);
    progEn = 1'b1;
    step();
    chk("R5 pair loaded while disabled", {effN, effM}, {expN, expM});

    // R9 R11: recovery from straps, override set
    ctrlByte = 8'b0101_1010;
    recovMode = 1'b1; recovSel = 1'b0;
    step();
    chk("R11 entry pulse", freqChg, 1);
    chk("R9 straps in recovery", effSel, held);
    chk("R9 no N/M from straps", {useNM, effN, effM}, 0);
    step();
    chk("R11 entry pulse single", freqChg, 0);

    // R8: writes in recovery
    progN = 8'd200; progM = 7'd3; nWrStb = 1'b1; mWrStb = 1'b1; txnEnd = 1'b1;
    step();
    nWrStb = 1'b0; mWrStb = 1'b0; txnEnd = 1'b0;
    chk("R8 no load in recovery", freqChg, 0);
    chk("R8 no reject in recovery", cfgReject, 0);
    progN = 8'd2; progM = 7'd90; txnEnd = 1'b1; nWrStb = 1'b1;
    step();
    nWrStb = 1'b0; txnEnd = 1'b0;
    chk("R8 bad pair ignored", cfgReject, 0);

    // R9: recovery N/M source
    recovSel = 1'b1; recovN = 8'd77; recovM = 7'd40;
    step();
    chk("R9 recovery useNM", useNM, 1);
    chk("R9 recovery pair", {effN, effM}, {8'd77, 7'd40});
    chk("R9 select via override", effSel, regSelOf(8'b0101_1010));

    recovMode = 1'b0;
    step();
    chk("R11 exit pulse", freqChg, 1);
    chk("R8 pair untouched", {effN, effM}, {expN, expM});
    step();
    chk("R11 exit pulse single", freqChg, 0);

    // R8: pending write dropped across recovery
    progN = 8'd100; progM = 7'd2; nWrStb = 1'b1;
    step();
    nWrStb = 1'b0; recovMode = 1'b1;
    step();
    recovMode = 1'b0;
    step();
    txnEnd = 1'b1;
    step();
    txnEnd = 1'b0;
    chk("R8 pending dropped", freqChg, 0);
    chk("R8 pair kept after drop", {effN, effM}, {expN, expM});

    finish();
  end
endmodule